// File: doc/BRIEF.md
# DMA Channel Request Generator

This block sits in front of one channel of a DMA transfer engine and decides when that channel asks for a transfer. A 4-bit select code picks where requests come from. The internal auto source requests whenever the channel may run. The external source is an active-low pin that is detected either on its low level or on its falling edge. The on-chip sources are three peripheral event lines: serial receive-full, serial transmit-empty and timer compare-match. The same code also tells the engine which address mode to use. This is either dual addressing, or single addressing with a direction.

Requests leave as a level on `req_out` that stays high until the engine returns `req_ack`. A request can only be raised while five conditions hold together: the channel enable and the master enable are set, and the transfer-end flag, the NMI flag and the address-error flag are all clear. When any of these conditions drops, the outstanding request disappears in that same cycle. A latched edge is discarded at the next clock.

The control is a three-state machine. ST_OFF is entered from any state when the enable gate is closed or the code is unassigned. It leaves for ST_WAIT once the gate opens. ST_WAIT moves to ST_REQ when the selected source triggers. ST_REQ returns to ST_WAIT when `req_ack` is seen. In ST_WAIT the source is sampled again, so auto mode produces one request per acknowledge.

Top module: `dma_req_gen`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `req_out` is 0.
- R2: `req_out` can be 1 only when `chan_en`=1, `master_en`=1, `xfer_end`=0, `nmi_flag`=0 and `addr_err`=0. In auto mode, opening this gate raises `req_out` after exactly two clock edges.
- R3: Code 0100 selects auto-request. With `req_ack` pulsed for one cycle, `req_out` drops for one cycle and then rises again.
- R4: Codes 0000, 0010 and 0011 select the external pin `ext_req_n`. With `detect_edge`=0, a low level raises `req_out` on the third edge. The pin is sampled again after each acknowledge, so a pin that is still low produces a new request.
- R5: With `detect_edge`=1, a high-to-low transition of `ext_req_n` raises `req_out` on the fourth edge. After the acknowledge, a pin that stays low produces no further request until it goes high and falls again.
- R6: Once raised, `req_out` holds while `req_ack` is 0 and the gate stays open. An acknowledge seen in a requesting cycle lowers it for the next cycle.
- R7: Code 0101 selects `periph_rx_full`, 0110 selects `periph_tx_empty` and 0111 selects `periph_cmp_match`. A high on the selected line raises `req_out` one edge later. The two lines not selected have no effect.
- R8: `dual_mode` is 1 for codes 0000 and 0100 to 0111, and 0 otherwise. `single_dir` is 1 only for code 0011 (memory to device). Code 0010 gives both 0 (device to memory).
- R9: Codes 0001 and 1000 to 1111 are unassigned. They set `cfg_invalid`=1 and never raise `req_out`, whatever the pin and peripheral lines do.
- R10: If `xfer_end`, `nmi_flag` or `addr_err` rises, `req_out` falls in the same cycle. An edge latched but not yet served is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_code | input | 4 | Request-source and address-mode select |
| detect_edge | input | 1 | External pin detection: 0 low level, 1 falling edge |
| chan_en | input | 1 | Channel enable |
| master_en | input | 1 | Global master enable |
| xfer_end | input | 1 | Transfer-end flag of the channel |
| nmi_flag | input | 1 | Global NMI abort flag |
| addr_err | input | 1 | Global address-error abort flag |
| ext_req_n | input | 1 | External request pin, active low, asynchronous |
| periph_rx_full | input | 1 | Serial receive-data-full event |
| periph_tx_empty | input | 1 | Serial transmit-data-empty event |
| periph_cmp_match | input | 1 | Timer capture/compare-match A event |
| req_ack | input | 1 | Acknowledge from the transfer engine |
| req_out | output | 1 | Transfer request strobe |
| dual_mode | output | 1 | Dual-address mode selected |
| single_dir | output | 1 | Single-address direction: 1 memory to device |
| cfg_invalid | output | 1 | Select code is unassigned |

## Verification
The hardest case to reach is an abort that arrives between the moment a falling edge is latched and the moment the machine turns it into a request. There is only one cycle in which the edge is held but not yet visible at `req_out`. The bench counts the synchronizer and latch stages from the negedge at which it drops the pin. It raises `nmi_flag` for exactly that one cycle, then checks that the request never comes while the pin stays low. A second hard case is edge mode with the pin held low through an acknowledge. The bench checks that the level alone does not raise a second request, and that a fresh fall does.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2
    } req_state_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_EXT  = 3'd1,
        SRC_AUTO = 3'd2,
        SRC_RX   = 3'd3,
        SRC_TX   = 3'd4,
        SRC_CMP  = 3'd5
    } req_src_e;

    typedef struct packed {
        req_src_e src;
        logic     dual;
        logic     dir_m2d;
        logic     invalid;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [3:0] code);
        sel_dec_t d;
        d = '{src: SRC_NONE, dual: 1'b0, dir_m2d: 1'b0, invalid: 1'b1};
        case (code)
            4'b0000: d = '{src: SRC_EXT,  dual: 1'b1, dir_m2d: 1'b0, invalid: 1'b0};
            4'b0010: d = '{src: SRC_EXT,  dual: 1'b0, dir_m2d: 1'b0, invalid: 1'b0};
            4'b0011: d = '{src: SRC_EXT,  dual: 1'b0, dir_m2d: 1'b1, invalid: 1'b0};
            4'b0100: d = '{src: SRC_AUTO, dual: 1'b1, dir_m2d: 1'b0, invalid: 1'b0};
            4'b0101: d = '{src: SRC_RX,   dual: 1'b1, dir_m2d: 1'b0, invalid: 1'b0};
            4'b0110: d = '{src: SRC_TX,   dual: 1'b1, dir_m2d: 1'b0, invalid: 1'b0};
            4'b0111: d = '{src: SRC_CMP,  dual: 1'b1, dir_m2d: 1'b0, invalid: 1'b0};
            default: d = '{src: SRC_NONE, dual: 1'b0, dir_m2d: 1'b0, invalid: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RESET_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = stg_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,       // synchronized, active low
    input  logic edge_mode,   // 1: falling edge, 0: low level
    input  logic enable,      // gate open and external source selected
    input  logic consume,     // request acknowledged this cycle
    output logic trigger
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall = edge_mode & prev_q & ~pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (!enable) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= (pend_q & ~consume) | fall;
            end
        end
    end

    assign trigger = edge_mode ? pend_q : ~pin_n;

    AST_FALL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && edge_mode && prev_q && !pin_n) |=> pend_q); // R5
    AST_PEND_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend_q); // R10
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
    import dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_open,
    input  logic trigger,
    input  logic ack,
    output logic req,
    output logic busy
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (gate_open) state_d = ST_WAIT;
            ST_WAIT: if (trigger)   state_d = ST_REQ;
            ST_REQ:  if (ack)       state_d = ST_WAIT;
            default:                state_d = ST_OFF;
        endcase
        if (!gate_open) state_d = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        req  = (state_q == ST_REQ) && gate_open;
        busy = (state_q == ST_REQ);
    end

    AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> state_q == ST_OFF); // R2
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && !ack && gate_open) |=> state_q == ST_REQ); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && ack && gate_open) |=> state_q == ST_WAIT); // R6
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
    import dma_req_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel_code,
    input  logic       detect_edge,
    input  logic       chan_en,
    input  logic       master_en,
    input  logic       xfer_end,
    input  logic       nmi_flag,
    input  logic       addr_err,
    input  logic       ext_req_n,
    input  logic       periph_rx_full,
    input  logic       periph_tx_empty,
    input  logic       periph_cmp_match,
    input  logic       req_ack,
    output logic       req_out,
    output logic       dual_mode,
    output logic       single_dir,
    output logic       cfg_invalid
);
    sel_dec_t dec;
    logic     gate_open;
    logic     pin_sync_n;
    logic     ext_trig;
    logic     trig;
    logic     fsm_busy;
    logic     consume;

    assign dec       = decode_sel(sel_code);
    assign gate_open = chan_en & master_en & ~xfer_end & ~nmi_flag & ~addr_err & ~dec.invalid;
    assign consume   = fsm_busy & req_ack;

    dma_req_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ext_req_n),
        .q_out (pin_sync_n)
    );

    dma_req_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_sync_n),
        .edge_mode (detect_edge),
        .enable    (gate_open && (dec.src == SRC_EXT)),
        .consume   (consume),
        .trigger   (ext_trig)
    );

    always_comb begin
        unique case (dec.src)
            SRC_EXT:  trig = ext_trig;
            SRC_AUTO: trig = 1'b1;
            SRC_RX:   trig = periph_rx_full;
            SRC_TX:   trig = periph_tx_empty;
            SRC_CMP:  trig = periph_cmp_match;
            default:  trig = 1'b0;
        endcase
    end

    dma_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_open (gate_open),
        .trigger   (trig),
        .ack       (req_ack),
        .req       (req_out),
        .busy      (fsm_busy)
    );

    assign dual_mode   = dec.dual;
    assign single_dir  = dec.dir_m2d;
    assign cfg_invalid = dec.invalid;

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !req_out); // R9
    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dual_mode && single_dir) && !(cfg_invalid && (dual_mode || single_dir))); // R8
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end || nmi_flag || addr_err) |-> !req_out); // R10
    AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out && req_ack) |=> !req_out); // R3
endmodule

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel_code = 4'b0100;
    logic       detect_edge = 1'b0;
    logic       chan_en = 1'b0, master_en = 1'b0;
    logic       xfer_end = 1'b0, nmi_flag = 1'b0, addr_err = 1'b0;
    logic       ext_req_n = 1'b1;
    logic       periph_rx_full = 1'b0, periph_tx_empty = 1'b0, periph_cmp_match = 1'b0;
    logic       req_ack = 1'b0;
    logic       req_out, dual_mode, single_dir, cfg_invalid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_gen dut (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .detect_edge(detect_edge),
        .chan_en(chan_en), .master_en(master_en), .xfer_end(xfer_end),
        .nmi_flag(nmi_flag), .addr_err(addr_err), .ext_req_n(ext_req_n),
        .periph_rx_full(periph_rx_full), .periph_tx_empty(periph_tx_empty),
        .periph_cmp_match(periph_cmp_match), .req_ack(req_ack),
        .req_out(req_out), .dual_mode(dual_mode), .single_dir(single_dir),
        .cfg_invalid(cfg_invalid)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_gate();
        chan_en = 1'b1; master_en = 1'b1;
        xfer_end = 1'b0; nmi_flag = 1'b0; addr_err = 1'b0;
    endtask

    task automatic close_gate();
        chan_en = 1'b0; req_ack = 1'b0;
        cyc(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk("R1 in reset", req_out, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after release", req_out, 1'b0);

        // R8 / R9: sweep of all select codes
        for (int c = 0; c < 16; c++) begin
            logic inv, dual, dir;
            sel_code = c[3:0];
            #1;
            inv  = (c == 1) || (c >= 8);
            dual = !inv && (c != 2) && (c != 3);
            dir  = (c == 3);
            chk("R9 cfg_invalid", cfg_invalid, inv);
            chk("R8 dual_mode", dual_mode, dual);
            chk("R8 single_dir", single_dir, dir);
        end

        // R9: unassigned codes with every source active never request
        ext_req_n = 1'b0; periph_rx_full = 1'b1; periph_tx_empty = 1'b1; periph_cmp_match = 1'b1;
        open_gate();
        for (int c = 0; c < 16; c++) begin
            if ((c == 1) || (c >= 8)) begin
                sel_code = c[3:0];
                cyc(4);
                chk("R9 no request", req_out, 1'b0);
            end
        end
        ext_req_n = 1'b1; periph_rx_full = 1'b0; periph_tx_empty = 1'b0; periph_cmp_match = 1'b0;
        close_gate();

        // R2: all 32 combinations of the five gate conditions, auto mode
        sel_code = 4'b0100;
        for (int i = 0; i < 32; i++) begin
            close_gate();
            xfer_end = 1'b0; nmi_flag = 1'b0; addr_err = 1'b0;
            chan_en = i[0]; master_en = i[1]; xfer_end = i[2]; nmi_flag = i[3]; addr_err = i[4];
            cyc(1);
            chk("R2 not before second edge", req_out, 1'b0);
            cyc(1);
            chk("R2 gate combination", req_out, (i == 3));
        end
        close_gate();
        xfer_end = 1'b0; nmi_flag = 1'b0; addr_err = 1'b0;

        // R3 / R6: auto back-to-back, hold until ack
        open_gate();
        cyc(2);
        chk("R3 first request", req_out, 1'b1);
        cyc(4);
        chk("R6 held without ack", req_out, 1'b1);
        req_ack = 1'b1;
        cyc(1);
        req_ack = 1'b0;
        chk("R6 gap after ack", req_out, 1'b0);
        cyc(1);
        chk("R3 next request", req_out, 1'b1);

        // R10: abort drops request in same cycle, each flag
        for (int f = 0; f < 3; f++) begin
            xfer_end = (f == 0); nmi_flag = (f == 1); addr_err = (f == 2);
            #1;
            chk("R10 same-cycle drop", req_out, 1'b0);
            cyc(1);
            xfer_end = 1'b0; nmi_flag = 1'b0; addr_err = 1'b0;
            cyc(2);
            chk("R10 request returns", req_out, 1'b1);
        end
        close_gate();

        // R4: external level mode, code 0000
        sel_code = 4'b0000; detect_edge = 1'b0; ext_req_n = 1'b1;
        open_gate();
        cyc(3);
        chk("R4 idle pin", req_out, 1'b0);
        ext_req_n = 1'b0;
        cyc(2);
        chk("R4 not yet", req_out, 1'b0);
        cyc(1);
        chk("R4 level request", req_out, 1'b1);
        req_ack = 1'b1;
        cyc(1);
        req_ack = 1'b0;
        chk("R4 gap", req_out, 1'b0);
        cyc(1);
        chk("R4 resampled low", req_out, 1'b1);
        ext_req_n = 1'b1;
        cyc(3);
        req_ack = 1'b1;
        cyc(1);
        req_ack = 1'b0;
        cyc(3);
        chk("R4 pin high no request", req_out, 1'b0);
        close_gate();

        // R5: external edge mode, code 0010
        sel_code = 4'b0010; detect_edge = 1'b1; ext_req_n = 1'b1;
        open_gate();
        cyc(3);
        ext_req_n = 1'b0;
        cyc(3);
        chk("R5 not yet", req_out, 1'b0);
        cyc(1);
        chk("R5 edge request", req_out, 1'b1);
        req_ack = 1'b1;
        cyc(1);
        req_ack = 1'b0;
        chk("R5 gap", req_out, 1'b0);
        cyc(4);
        chk("R5 low level ignored", req_out, 1'b0);
        ext_req_n = 1'b1;
        cyc(3);
        ext_req_n = 1'b0;
        cyc(4);
        chk("R5 second fall", req_out, 1'b1);
        req_ack = 1'b1;
        cyc(1);
        req_ack = 1'b0;

        // R10: abort between edge latch and request, code 0011
        sel_code = 4'b0011;
        ext_req_n = 1'b1;
        cyc(3);
        ext_req_n = 1'b0;
        cyc(3);
        nmi_flag = 1'b1;
        cyc(1);
        nmi_flag = 1'b0;
        chk("R10 abort blocks", req_out, 1'b0);
        cyc(4);
        chk("R10 latched edge discarded", req_out, 1'b0);
        ext_req_n = 1'b1;
        close_gate();
        detect_edge = 1'b0;

        // R7: on-chip sources, only the selected line counts
        for (int s = 0; s < 3; s++) begin
            sel_code = 4'(5 + s);
            open_gate();
            cyc(2);
            periph_rx_full = (s != 0); periph_tx_empty = (s != 1); periph_cmp_match = (s != 2);
            cyc(3);
            chk("R7 other lines ignored", req_out, 1'b0);
            periph_rx_full = 1'b1; periph_tx_empty = 1'b1; periph_cmp_match = 1'b1;
            cyc(1);
            chk("R7 selected line", req_out, 1'b1);
            periph_rx_full = 1'b0; periph_tx_empty = 1'b0; periph_cmp_match = 1'b0;
            req_ack = 1'b1;
            cyc(1);
            req_ack = 1'b0;
            cyc(2);
            chk("R7 line low no request", req_out, 1'b0);
            close_gate();
        end

        finish_run();
    end
endmodule